// File: doc/BRIEF.md
# Time-Scheduled Square-Wave Pin Driver

This block drives a single output pin with a 50 % duty-cycle square wave whose edges fall at exact values of the precision time counter. Software first writes two values. The first is a 64-bit absolute start time. The second is a 32-bit half-period, which is the number of ticks between two consecutive edges. Software then sets the start flag in a command word. The current precision time comes in as an input on every clock.

At the first clock where the time has reached the start time, the pin changes level. From then on the next edge time is the previous edge time plus the half-period, and the pin changes level again each time the clock reaches it. Each event is a pure level change and never a pulse that returns. The resulting output frequency is 1e9 / (half_period × 8 ns × 2) when one tick is 8 ns.

A stop flag in the command word freezes the pin at its present level and disarms the scheduler. A start request is dropped when the start time is not in the future or when the half-period is zero.

Top module: `ptp_pin_toggler`

## Requirements
- R1: After reset the pin output is low and the `armed` output is low.
- R2: A command cycle with bit 28 of `cmd_word` set (start) arms the scheduler in the following cycle, provided the held half-period is non-zero and the held start time is strictly greater than `ptp_time` in that cycle. `armed` can rise only after such a cycle.
- R3: While armed, the pin inverts at the first clock edge where `ptp_time` is greater than or equal to the scheduled edge time, and is visible after that edge. The pin never changes while disarmed.
- R4: A start command whose start time is less than or equal to `ptp_time` changes neither `armed` nor the pin.
- R5: A start command issued while the held half-period is zero changes neither `armed` nor the pin.
- R6: After every toggle the scheduled edge time advances by exactly the half-period, so the pin keeps a 50 % duty cycle locked to the time counter.
- R7: A command cycle with bit 27 of `cmd_word` set (stop) clears `armed` in the next cycle and holds the pin at its current level.
- R8: Because the comparison is greater-or-equal, a forward jump of `ptp_time` across several edge times produces one toggle per clock until the scheduled edge time has passed the current time. No edge is lost.
- R9: When bits 27 and 28 are both set in one command cycle, the stop takes effect and no toggle happens at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptp_time | input | 64 | Current precision time in ticks |
| start_wr | input | 1 | Load strobe for the start time |
| start_din | input | 64 | Absolute start time in ticks |
| half_wr | input | 1 | Load strobe for the half-period |
| half_din | input | 32 | Ticks between two consecutive edges |
| cmd_valid | input | 1 | Command word qualifier |
| cmd_word | input | 32 | Command word: bit 28 start, bit 27 stop |
| pin_out | output | 1 | Square-wave output pin |
| armed | output | 1 | High while the scheduler is running |

## Verification
The bench targets these corner cases and the faults that would expose a wrong design:
- **Start time equal to the current time.** A design comparing with greater-or-equal here would arm and then toggle at once.
- **Zero half-period.** Accepting it would freeze the edge time and toggle the pin on every clock.
- **Time jump over several edges.** An equality comparator would miss the edge and stop toggling for good.
- **Start and stop in the same cycle.** Giving start priority would leave the pin running.
- **Stop cycle.** A stop that did not hold the pin would let it drift or reset to low.

Random sequences of writes, commands and time steps check the pin and `armed` against a cycle model on every clock.

// File: rtl/ptp_tog_pkg.sv
package ptp_tog_pkg;
  localparam int unsigned CMD_START_BIT = 28;
  localparam int unsigned CMD_STOP_BIT  = 27;

  typedef struct packed {
    logic start;
    logic stop;
  } tog_cmd_t;
endpackage

// File: rtl/ptp_tog_cmd_decode.sv
module ptp_tog_cmd_decode
  import ptp_tog_pkg::*;
#(
  parameter int unsigned CMD_W = 32
) (
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_word_i,
  output tog_cmd_t         cmd_o
);
  logic cmd_unused;

  always_comb begin
    cmd_o.start = cmd_valid_i & cmd_word_i[CMD_START_BIT];
    cmd_o.stop  = cmd_valid_i & cmd_word_i[CMD_STOP_BIT];
  end

  assign cmd_unused = ^cmd_word_i;
endmodule

// File: rtl/ptp_tog_param_regs.sv
module ptp_tog_param_regs #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr_i,
  input  logic [TIME_W-1:0] start_din_i,
  input  logic              half_wr_i,
  input  logic [HALF_W-1:0] half_din_i,
  output logic [TIME_W-1:0] start_q_o,
  output logic [HALF_W-1:0] half_q_o
);
  logic [TIME_W-1:0] start_q;
  logic [HALF_W-1:0] half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (start_wr_i) begin
      start_q <= start_din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
    end else if (half_wr_i) begin
      half_q <= half_din_i;
    end
  end

  assign start_q_o = start_q;
  assign half_q_o  = half_q;
endmodule

// File: rtl/ptp_tog_sched.sv
module ptp_tog_sched
  import ptp_tog_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tog_cmd_t          cmd_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] start_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              armed_o,
  output logic              toggle_o
);
  localparam int unsigned PAD_W = TIME_W - HALF_W;

  logic              armed_q, armed_d;
  logic [TIME_W-1:0] next_q, next_d;
  logic              start_ok, reached, upd_en;

  always_comb begin
    start_ok = cmd_i.start && (half_i != '0) && (start_i > time_i);
    reached  = armed_q && (time_i >= next_q);
    armed_d  = armed_q;
    next_d   = next_q;
    toggle_o = 1'b0;
    if (cmd_i.stop) begin
      armed_d = 1'b0;
    end else if (start_ok) begin
      armed_d = 1'b1;
      next_d  = start_i;
    end else if (reached) begin
      toggle_o = 1'b1;
      next_d   = next_q + {{PAD_W{1'b0}}, half_i};
    end
    upd_en = cmd_i.stop | start_ok | reached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      next_q  <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      next_q  <= next_d;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/ptp_tog_pin.sv
module ptp_tog_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_i,
  output logic pin_o
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = ~pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (toggle_i) begin
      pin_q <= pin_d;
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/ptp_pin_toggler.sv
module ptp_pin_toggler
  import ptp_tog_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned CMD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] ptp_time,
  input  logic              start_wr,
  input  logic [TIME_W-1:0] start_din,
  input  logic              half_wr,
  input  logic [HALF_W-1:0] half_din,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              pin_out,
  output logic              armed
);
  tog_cmd_t          cmd;
  logic [TIME_W-1:0] start_q;
  logic [HALF_W-1:0] half_q;
  logic              toggle;

  ptp_tog_cmd_decode #(.CMD_W(CMD_W)) dec_i (
    .cmd_valid_i (cmd_valid),
    .cmd_word_i  (cmd_word),
    .cmd_o       (cmd)
  );

  ptp_tog_param_regs #(.TIME_W(TIME_W), .HALF_W(HALF_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_wr_i  (start_wr),
    .start_din_i (start_din),
    .half_wr_i   (half_wr),
    .half_din_i  (half_din),
    .start_q_o   (start_q),
    .half_q_o    (half_q)
  );

  ptp_tog_sched #(.TIME_W(TIME_W), .HALF_W(HALF_W)) sched_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd),
    .time_i   (ptp_time),
    .start_i  (start_q),
    .half_i   (half_q),
    .armed_o  (armed),
    .toggle_o (toggle)
  );

  ptp_tog_pin pin_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .toggle_i (toggle),
    .pin_o    (pin_out)
  );
endmodule

// File: rtl/ptp_pin_toggler_chk.sv
module ptp_pin_toggler_chk
  import ptp_tog_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned CMD_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_word,
  input logic [TIME_W-1:0] ptp_time,
  input logic [TIME_W-1:0] start_q,
  input logic [HALF_W-1:0] half_q,
  input logic              pin_out,
  input logic              armed
);
  AST_ARM_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(cmd_valid && cmd_word[CMD_START_BIT])); // R2

  AST_PIN_MOVES_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> $past(armed)); // R3

  AST_PAST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[CMD_START_BIT] && !armed && start_q <= ptp_time) |=> !armed); // R4

  AST_ZERO_HALF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[CMD_START_BIT] && !armed && half_q == '0) |=> !armed); // R5

  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[CMD_STOP_BIT]) |=> !armed); // R7

  AST_STOP_HOLDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[CMD_STOP_BIT] && cmd_word[CMD_START_BIT]) |=> $stable(pin_out)); // R9
endmodule

bind ptp_pin_toggler ptp_pin_toggler_chk #(
  .TIME_W(TIME_W), .HALF_W(HALF_W), .CMD_W(CMD_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_word  (cmd_word),
  .ptp_time  (ptp_time),
  .start_q   (start_q),
  .half_q    (half_q),
  .pin_out   (pin_out),
  .armed     (armed)
);

// File: tb/ptp_pin_toggler_tb_top.sv
`timescale 1ns/1ps
module ptp_pin_toggler_tb_top;
  logic        clk;
  logic        rst_n;
  logic [63:0] ptp_time;
  logic        start_wr;
  logic [63:0] start_din;
  logic        half_wr;
  logic [31:0] half_din;
  logic        cmd_valid;
  logic [31:0] cmd_word;
  logic        pin_out;
  logic        armed;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench cycle model
  logic        m_armed, m_pin;
  logic [63:0] m_next, m_start;
  logic [31:0] m_half;
  logic [63:0] step;

  localparam logic [31:0] CMD_START = 32'h1000_0000; // bit 28
  localparam logic [31:0] CMD_STOP  = 32'h0800_0000; // bit 27

  ptp_pin_toggler dut_i (
    .clk(clk), .rst_n(rst_n), .ptp_time(ptp_time),
    .start_wr(start_wr), .start_din(start_din),
    .half_wr(half_wr), .half_din(half_din),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .pin_out(pin_out), .armed(armed)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h time=%0d", tag, act, exp, ptp_time);
    end
  endtask

  // Advance one clock: update model from the inputs seen at the edge,
  // compare at the falling edge, then clear strobes and advance time.
  task automatic tick();
    logic st, sp, ok, hit;
    @(posedge clk);
    st  = cmd_valid && cmd_word[28];
    sp  = cmd_valid && cmd_word[27];
    ok  = st && (m_half != 0) && (m_start > ptp_time);
    hit = m_armed && (ptp_time >= m_next);
    if (sp) m_armed = 1'b0;
    else if (ok) begin m_armed = 1'b1; m_next = m_start; end
    else if (hit) begin m_pin = ~m_pin; m_next = m_next + {32'd0, m_half}; end
    if (start_wr) m_start = start_din;
    if (half_wr)  m_half  = half_din;
    @(negedge clk);
    chk("R3 R6 pin level", {63'd0, pin_out}, {63'd0, m_pin});
    chk("R2 R7 armed", {63'd0, armed}, {63'd0, m_armed});
    start_wr = 0; half_wr = 0; cmd_valid = 0; cmd_word = 0;
    ptp_time = ptp_time + step;
    step = 1;
  endtask

  task automatic load(input logic [63:0] st, input logic [31:0] hp);
    start_wr = 1; start_din = st; half_wr = 1; half_din = hp;
    tick();
  endtask

  task automatic cmd(input logic [31:0] w);
    cmd_valid = 1; cmd_word = w;
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic pin_hold;
    logic [63:0] t0;
    void'($urandom(32'd1234));
    rst_n = 0; ptp_time = 64'd1000; start_wr = 0; start_din = 0;
    half_wr = 0; half_din = 0; cmd_valid = 0; cmd_word = 0; step = 1;
    m_armed = 0; m_pin = 0; m_next = 0; m_start = 0; m_half = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset pin", {63'd0, pin_out}, 64'd0);
    chk("R1 reset armed", {63'd0, armed}, 64'd0);
    rst_n = 1;
    tick();

    // R5: zero half-period refused
    load(ptp_time + 20, 32'd0);
    cmd(CMD_START);
    chk("R5 zero half ignored", {63'd0, armed}, 64'd0);

    // R4: start equal to current time refused
    load(ptp_time + 1, 32'd5); // start == time at the command edge
    cmd(CMD_START);
    chk("R4 start not in future", {63'd0, armed}, 64'd0);

    // R2 / R3: arm and first toggle exactly at start time
    load(ptp_time + 8, 32'd4);
    t0 = m_start;
    cmd(CMD_START);
    chk("R2 armed after start", {63'd0, armed}, 64'd1);
    while (ptp_time < t0) tick();
    chk("R3 pin low before start", {63'd0, pin_out}, 64'd0);
    tick();
    chk("R3 first toggle at start", {63'd0, pin_out}, 64'd1);
    // R6: next edge one half-period later
    repeat (3) tick();
    chk("R6 held during half period", {63'd0, pin_out}, 64'd1);
    tick();
    chk("R6 second toggle", {63'd0, pin_out}, 64'd0);
    repeat (30) tick();

    // R8: forward jump over three edges
    step = 64'd13;
    tick();
    repeat (5) tick();

    // R7: stop freezes pin
    pin_hold = pin_out;
    cmd(CMD_STOP);
    repeat (20) tick();
    chk("R7 pin frozen after stop", {63'd0, pin_out}, {63'd0, pin_hold});
    chk("R7 disarmed", {63'd0, armed}, 64'd0);

    // R9: both bits -> stop wins
    load(ptp_time + 6, 32'd3);
    cmd(CMD_START);
    repeat (10) tick();
    pin_hold = pin_out;
    cmd(CMD_START | CMD_STOP);
    chk("R9 stop wins", {63'd0, armed}, 64'd0);
    chk("R9 pin held", {63'd0, pin_out}, {63'd0, pin_hold});

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r == 0) load(ptp_time + ($urandom % 24), $urandom % 9);
      else if (r == 1) cmd(CMD_START);
      else if (r == 2) cmd(CMD_STOP);
      else if (r == 3) cmd(($urandom % 2) ? (CMD_START | CMD_STOP) : 32'h0000_0001);
      else if (r == 4) begin step = 64'($urandom % 40); tick(); end
      else tick();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule